// File: doc/BRIEF.md
# Tamper Security Supervisor

This block decides whether a battery-backed security domain can be trusted. It watches ten tamper event lines: voltage, clock, temperature, secure-controller alarm, external boot, external input A, external input B, wire mesh, time-counter overflow and monotonic-counter overflow. It latches a detect bit for every event it sees. An event whose enable is set in the tamper configuration register raises the security-violation flag. The unit then holds one of three conditions: non-valid, failure (violation set), or valid (neither flag set).

Recovery from failure follows a fixed order. The software first zeroes the enables. It then clears the detect bits, then the violation flag, and last the non-valid flag. Each step is a write-one-to-clear on the status register, and a step is refused until the steps before it are done.

Locks guard the sequence:
- A configuration soft lock freezes the enables until the next system power-on reset.
- A configuration hard lock and a failure hard lock hold until the battery-domain reset.
- A violation found without the non-valid flag can be cleared only after a system power-on reset, which adds the non-valid flag.

All registers sit in the battery domain and are clocked by `clk`. The register access port is a plain single-cycle write strobe.

Top module: `tamper_supervisor`

## Requirements
- R1: The battery reset (`bat_rst_n` low, asynchronous) clears the enables, the control bits, all detect bits and the violation flag, and sets the non-valid flag. Afterwards `status_o` = 0x000002, `cfg_o` = 0, `ctrl_o` = 0 and `irq_o` = 0.
- R2: An event on `evt_i[i]` sets its detect bit in `status_o` one cycle later, whether or not the source is enabled. Source i (0..7) maps to status bit 16+i. Source 8 (time overflow) maps to bit 2 and source 9 (monotonic overflow) maps to bit 3.
- R3: An event on a source whose enable bit `cfg_o[i]` is 1 sets the violation flag `status_o[0]` one cycle later. An event on a disabled source leaves the flag unchanged.
- R4: A write with `wr_sel_i`=0 loads `wr_data_i[9:0]` into the enables. The write is ignored while the soft lock (`ctrl_o[1]`) or the configuration hard lock (`ctrl_o[2]`) is set, or while `sys_por_i` is high.
- R5: A cycle with `sys_por_i` high has the following effects:
  - it clears the soft lock and the interrupt enable;
  - it keeps both hard locks and the enables;
  - it sets the non-valid flag if the violation flag is set;
  - it ignores every write in that cycle.
- R6: While the non-valid flag is 0, the violation flag cannot be cleared.
- R7: A status write (`wr_sel_i`=1) with bit 0 set clears the violation flag only when all four of these hold: the non-valid flag is 1, all enables are 0, all detect bits are 0, and the failure hard lock is 0.
- R8: A status write clears detect bit i on a one at its status position only when enable i is 0 and the failure hard lock is 0. An event in the same cycle keeps the bit set.
- R9: A status write with bit 1 set clears the non-valid flag only when the violation flag is already 0. A write with both bits set therefore clears the violation flag only.
- R10: While the failure hard lock (`ctrl_o[3]`) is set, every status clear is refused. Only the battery reset removes the lock.
- R11: `irq_o` is 1 exactly when the violation flag and the interrupt enable (`ctrl_o[0]`) are both 1.
- R12: A control write (`wr_sel_i`=2) has the following effects:
  - it loads the interrupt enable from bit 0;
  - it sets the soft lock, configuration hard lock and failure hard lock from ones in bits 1, 2 and 3;
  - a zero written to a lock bit has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Battery-domain clock |
| bat_rst_n | input | 1 | Battery-domain reset, active low, asynchronous |
| sys_por_i | input | 1 | System power-on reset, active high, synchronous |
| evt_i | input | 10 | Tamper event lines, source order as in R2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 = configuration, 1 = status clear, 2 = control |
| wr_data_i | input | 24 | Write data |
| status_o | output | 24 | Detect bits, non-valid flag (bit 1) and violation flag (bit 0) |
| cfg_o | output | 10 | Per-source tamper enables |
| ctrl_o | output | 4 | Interrupt enable, soft lock, configuration hard lock, failure hard lock |
| irq_o | output | 1 | Violation interrupt |

## Verification
Every state bit of the block appears directly on `status_o`, `cfg_o` or `ctrl_o`. A wrong transition therefore shows at the ports on the clock edge that causes it.

Faults that could otherwise hide are exposed by recovery writes issued out of order. A guard that is missing or misplaced lets a flag fall one step early, and the bench sees it at the next sample. A lock that leaks shows up as an enable or control value that changes after a write that should have been ignored.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int NSRC   = 10;  // tamper event sources
  localparam int STAT_W = 24;  // status register width
  localparam int CTRL_W = 4;   // control register width
  localparam int DATA_W = 24;  // write data width

  // register select codes
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // status bit positions
  localparam int ST_VIOL = 0;
  localparam int ST_NV   = 1;

  // control bit positions
  localparam int CT_IE   = 0;
  localparam int CT_SOFT = 1;
  localparam int CT_HARD = 2;
  localparam int CT_FAIL = 3;

  // status position of detect bit for source i
  function automatic int det_pos(input int i);
    return (i < 8) ? 16 + i : i - 6;
  endfunction
endpackage

// File: rtl/tamper_cfg_regs.sv
module tamper_cfg_regs
  import tamper_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int CW = CTRL_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          bat_rst_n,
  input  logic          sys_por_i,
  input  logic          wr_cfg_i,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] data_i,
  output logic [N-1:0]  cfg_o,
  output logic [CW-1:0] ctrl_o
);
  logic [N-1:0] cfg_q;
  logic ie_q, soft_q, hard_q, fail_q;

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) begin
      cfg_q  <= '0;
      ie_q   <= 1'b0;
      soft_q <= 1'b0;
      hard_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (sys_por_i) begin
      // system reset releases only the system-domain bits
      soft_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_cfg_i && !soft_q && !hard_q) cfg_q <= data_i[N-1:0];
      if (wr_ctrl_i) begin
        ie_q   <= data_i[CT_IE];
        soft_q <= soft_q | data_i[CT_SOFT];
        hard_q <= hard_q | data_i[CT_HARD];
        fail_q <= fail_q | data_i[CT_FAIL];
      end
    end
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[CT_IE]   = ie_q;
    ctrl_o[CT_SOFT] = soft_q;
    ctrl_o[CT_HARD] = hard_q;
    ctrl_o[CT_FAIL] = fail_q;
  end
  assign cfg_o = cfg_q;

  // R4: a set lock freezes the enables for the next cycle
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (soft_q || hard_q) |=> $stable(cfg_q));
  // R12: hard locks never fall without a battery reset
  a_r12_hard_sticky: assert property (@(posedge clk) disable iff (!bat_rst_n)
    hard_q |=> hard_q);
  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!bat_rst_n)
    fail_q |=> fail_q);
endmodule

// File: rtl/tamper_status.sv
module tamper_status
  import tamper_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         bat_rst_n,
  input  logic         sys_por_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] cfg_i,
  input  logic         fail_lock_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_data_i,
  output logic [N-1:0] det_o,
  output logic         nv_o,
  output logic         viol_o
);
  logic [N-1:0] det_q, det_clr;
  logic nv_q, viol_q;
  logic viol_set, viol_clr, nv_clr;

  for (genvar g = 0; g < N; g++) begin : g_det
    localparam int P = det_pos(g);
    assign det_clr[g] = clr_en_i && clr_data_i[P] && !cfg_i[g] && !fail_lock_i;
  end

  assign viol_set = |(evt_i & cfg_i);
  assign viol_clr = clr_en_i && clr_data_i[ST_VIOL] && nv_q && (cfg_i == '0)
                    && (det_q == '0) && !fail_lock_i;
  assign nv_clr   = clr_en_i && clr_data_i[ST_NV] && !viol_q && !fail_lock_i;

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) begin
      det_q  <= '0;
      nv_q   <= 1'b1;
      viol_q <= 1'b0;
    end else begin
      det_q  <= (det_q & ~det_clr) | evt_i;
      viol_q <= viol_set | (viol_q & ~viol_clr);
      nv_q   <= (nv_q | (sys_por_i & viol_q)) & ~nv_clr;
    end
  end

  assign det_o  = det_q;
  assign nv_o   = nv_q;
  assign viol_o = viol_q;

  // R6: failure without the non-valid flag is stuck
  a_r6_no_clear_valid: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (viol_q && !nv_q) |=> viol_q);
  // R9: the non-valid flag outlives the violation flag
  a_r9_nv_last: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (viol_q && nv_q) |=> nv_q);
  // R10: failure hard lock pins the violation flag
  a_r10_fail_pins: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (fail_lock_i && viol_q) |=> viol_q);
  // R7: violation falls only with no detect bit pending
  a_r7_fall_clean: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (viol_q && det_q != '0) |=> viol_q);
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
  import tamper_pkg::*;
(
  input  logic              clk,
  input  logic              bat_rst_n,
  input  logic              sys_por_i,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [NSRC-1:0]   cfg_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  logic [NSRC-1:0] det;
  logic nv, viol;
  logic wr_cfg, wr_ctrl, clr_en;

  assign wr_cfg  = wr_en_i && (wr_sel_i == SEL_CFG);
  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign clr_en  = wr_en_i && (wr_sel_i == SEL_STAT) && !sys_por_i;

  tamper_cfg_regs #(.N(NSRC), .CW(CTRL_W), .DW(DATA_W)) u_cfg (
    .clk       (clk),
    .bat_rst_n (bat_rst_n),
    .sys_por_i (sys_por_i),
    .wr_cfg_i  (wr_cfg),
    .wr_ctrl_i (wr_ctrl),
    .data_i    (wr_data_i),
    .cfg_o     (cfg_o),
    .ctrl_o    (ctrl_o)
  );

  tamper_status #(.N(NSRC), .W(STAT_W)) u_stat (
    .clk         (clk),
    .bat_rst_n   (bat_rst_n),
    .sys_por_i   (sys_por_i),
    .evt_i       (evt_i),
    .cfg_i       (cfg_o),
    .fail_lock_i (ctrl_o[CT_FAIL]),
    .clr_en_i    (clr_en),
    .clr_data_i  (wr_data_i),
    .det_o       (det),
    .nv_o        (nv),
    .viol_o      (viol)
  );

  always_comb begin
    status_o          = '0;
    status_o[ST_VIOL] = viol;
    status_o[ST_NV]   = nv;
    for (int i = 0; i < NSRC; i++) status_o[det_pos(i)] = det[i];
  end

  assign irq_o = viol & ctrl_o[CT_IE];

  // R3: an enabled event always trips the violation flag
  a_r3_enabled_trips: assert property (@(posedge clk) disable iff (!bat_rst_n)
    (|(evt_i & cfg_o)) |=> status_o[ST_VIOL]);
  // R2: a seen event is always recorded
  a_r2_event_recorded: assert property (@(posedge clk) disable iff (!bat_rst_n)
    evt_i[0] |=> status_o[16]);
endmodule

// File: tb/test_tamper_supervisor.sv
module test_tamper_supervisor;
  logic        clk = 1'b0;
  logic        bat_rst_n = 1'b0;
  logic        sys_por_i = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [23:0] wr_data_i = '0;
  logic [23:0] status_o;
  logic [9:0]  cfg_o;
  logic [3:0]  ctrl_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tamper_supervisor i_tamper_supervisor (
    .clk(clk), .bat_rst_n(bat_rst_n), .sys_por_i(sys_por_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .status_o(status_o), .cfg_o(cfg_o), .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  function automatic int pos(input int i);
    return (i < 8) ? 16 + i : i - 6;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    evt_i = 10'(1) << i;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic bat_rst();
    @(negedge clk); bat_rst_n = 1'b0;
    @(negedge clk); bat_rst_n = 1'b1;
  endtask

  task automatic sys_por();
    @(negedge clk); sys_por_i = 1'b1;
    @(negedge clk); sys_por_i = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    bat_rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(status_o), 32'h2);
    chk("R1 cfg", 32'(cfg_o), 0);
    chk("R1 ctrl", 32'(ctrl_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // sweep every source, enabled and disabled
    for (int i = 0; i < 10; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [23:0] pbit;
        pbit = 24'(1) << pos(i);
        bat_rst();
        chk("R1 status after battery reset", 32'(status_o), 32'h2);
        if (en == 1) begin
          wr(2'd0, 24'(1) << i);
          chk("R4 unlocked cfg write", 32'(cfg_o), 32'(1) << i);
        end
        pulse(i);
        chk("R2/R3 status after event", 32'(status_o), 32'(pbit | 24'h2 | 24'(en)));
        wr(2'd2, 24'h1);
        chk("R11 irq", 32'(irq_o), 32'(en));
        if (en == 1) begin
          wr(2'd1, 24'h1);
          chk("R7 viol held while enabled", 32'(status_o), 32'(pbit | 24'h3));
          wr(2'd1, pbit);
          chk("R8 detect held while enabled", 32'(status_o), 32'(pbit | 24'h3));
          wr(2'd0, 24'h0);
          wr(2'd1, pbit);
          chk("R8 detect cleared", 32'(status_o), 32'h3);
          wr(2'd1, 24'h3);
          chk("R9 both bits clears viol only", 32'(status_o), 32'h2);
          chk("R11 irq drops", 32'(irq_o), 0);
          wr(2'd1, 24'h2);
          chk("R9 nv cleared last", 32'(status_o), 32'h0);
        end else begin
          wr(2'd1, pbit);
          chk("R8 disabled detect cleared", 32'(status_o), 32'h2);
        end
      end
    end

    // valid-state failure with soft lock
    bat_rst();
    wr(2'd1, 24'h2);
    chk("R9 nv clear from non-valid", 32'(status_o), 32'h0);
    wr(2'd0, 24'h1);
    wr(2'd2, 24'h2);
    chk("R12 soft lock set", 32'(ctrl_o), 32'h2);
    pulse(0);
    chk("R3 failure from valid", 32'(status_o), 32'h10001);
    wr(2'd1, 24'h1);
    chk("R6 viol stuck without nv", 32'(status_o), 32'h10001);
    wr(2'd0, 24'h0);
    chk("R4 soft lock blocks cfg", 32'(cfg_o), 32'h1);
    sys_por();
    chk("R5 system reset adds nv", 32'(status_o), 32'h10003);
    chk("R5 soft lock released", 32'(ctrl_o), 32'h0);
    wr(2'd0, 24'h0);
    wr(2'd1, 24'h10000);
    wr(2'd1, 24'h1);
    wr(2'd1, 24'h2);
    chk("R7 full recovery", 32'(status_o), 32'h0);
    sys_por();
    chk("R5 no nv without viol", 32'(status_o), 32'h0);

    // configuration hard lock
    bat_rst();
    wr(2'd1, 24'h2);
    wr(2'd0, 24'h2);
    wr(2'd2, 24'h4);
    wr(2'd2, 24'h0);
    chk("R12 hard lock not cleared by zero", 32'(ctrl_o), 32'h4);
    pulse(1);
    chk("R3 source 1 trip", 32'(status_o), 32'h20001);
    sys_por();
    chk("R5 hard lock kept", 32'(ctrl_o), 32'h4);
    chk("R5 nv set", 32'(status_o), 32'h20003);
    wr(2'd0, 24'h0);
    chk("R4 hard lock blocks cfg", 32'(cfg_o), 32'h2);
    wr(2'd1, 24'h20000);
    wr(2'd1, 24'h1);
    chk("R7 recovery refused", 32'(status_o), 32'h20003);
    bat_rst();
    chk("R1 battery clears status", 32'(status_o), 32'h2);
    chk("R1 battery clears ctrl", 32'(ctrl_o), 32'h0);
    chk("R1 battery clears cfg", 32'(cfg_o), 32'h0);

    // failure hard lock
    bat_rst();
    wr(2'd0, 24'h200);
    wr(2'd2, 24'h8);
    pulse(9);
    chk("R2 monotonic overflow at bit 3", 32'(status_o), 32'hB);
    wr(2'd0, 24'h0);
    chk("R4 cfg write allowed", 32'(cfg_o), 32'h0);
    wr(2'd1, 24'h8);
    chk("R10 detect clear refused", 32'(status_o), 32'hB);
    wr(2'd1, 24'h1);
    chk("R10 viol clear refused", 32'(status_o), 32'hB);
    wr(2'd1, 24'h2);
    chk("R10 nv clear refused", 32'(status_o), 32'hB);
    bat_rst();
    chk("R1 battery removes fail lock", 32'(status_o), 32'h2);

    // event and clear in the same cycle
    bat_rst();
    @(negedge clk);
    evt_i = 10'h1;
    wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 24'h10000;
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
    chk("R8 event wins over clear", 32'(status_o), 32'h10002);

    summary();
    $finish;
  end
endmodule